// File: doc/BRIEF.md
# DMA Interrupt Source Selector

This block is glue logic between a host bus, a disk controller and a DMA controller. It decides which of the two interrupt requests reaches the single system interrupt input. It watches host writes to the disk controller's command register by looking at the select line, the write strobe, the register address and one bit of the write data. From these it keeps one bit of state, the route: whether the last command written was a sector read.

After a sector read, the system interrupt comes from the DMA controller's terminal-count interrupt. During a partial-sector DMA read the disk controller never reports completion, so only the DMA side can end the transfer. After any other command, the interrupt comes from the disk controller. This hides the early DMA interrupt that arrives during a write, before the data has reached the disk.

Both interrupt requests are treated as asynchronous. Each passes through a two-flop synchronizer before the multiplexer. The host bus signals are sampled on the block clock. The block has no stream data path, so it has no valid/ready handshake. Every pin is a plain level signal.

Top module: `irq_src_sel`

## Requirements
- R1: While reset is asserted, and on the first clock after it is released, `sys_irq` is 0 and the route points at the disk controller. With the default route, `dma_irq` alone never raises `sys_irq`.
- R2: After a command write whose data bit 4 is 0 (a sector read), `sys_irq` follows `dma_irq`, delayed by the synchronizer.
- R3: After a command write whose data bit 4 is 1 (any other command), `sys_irq` follows `disk_irq`, delayed by the synchronizer.
- R4: A write strobe with `bus_addr` different from the command register address (default 7) leaves the route unchanged.
- R5: A write strobe while `bus_sel_n` is high (inactive) leaves the route unchanged.
- R6: The route is updated on the rising edge of `bus_wr_n`. The bit taken is data bit 4 as sampled in the last clock cycle in which `bus_wr_n` was low. A change of the data bus in the cycle the strobe rises is ignored.
- R7: A change on the selected interrupt input appears on `sys_irq` after exactly two rising clock edges. It does not appear after one.
- R8: Activity on the interrupt input that is not selected has no effect on `sys_irq`.
- R9: Only data bit 4 of a command write matters; the other seven bits have no effect on the route.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_sel_n | input | 1 | Host select of the disk controller, active low |
| bus_wr_n | input | 1 | Host write strobe, active low |
| bus_addr | input | 3 | Host register address |
| bus_wdata | input | 8 | Host write data |
| dma_irq | input | 1 | DMA controller terminal-count interrupt, asynchronous |
| disk_irq | input | 1 | Disk controller interrupt, asynchronous |
| sys_irq | output | 1 | Interrupt to the system |

## Verification
A wrong route bit shows at the ports as soon as the two interrupt inputs differ. In that case `sys_irq` follows the wrong source two clocks after the inputs settle, and keeps doing so until the next command write. A wrong capture (wrong address, inactive select, or a data sample taken after the strobe) therefore shows up on the next toggle of either input. A wrong synchronizer depth shows in the exact edge on which `sys_irq` moves after an input change.

// File: rtl/irq_src_pkg.sv
package irq_src_pkg;
  // Route encoding: matches the command data bit (0 = sector read)
  typedef enum logic {
    ROUTE_DMA  = 1'b0,
    ROUTE_DISK = 1'b1
  } route_e;

  localparam int unsigned SRC_COUNT = 2;
  localparam int unsigned SRC_DMA   = 0;
  localparam int unsigned SRC_DISK  = 1;
endpackage

// File: rtl/cmd_snoop.sv
module cmd_snoop #(
  parameter int unsigned ADDR_W   = 3,
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned CMD_ADDR = 7,
  parameter int unsigned CMD_BIT  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_n,
  input  logic              wr_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output irq_src_pkg::route_e route
);
  import irq_src_pkg::*;

  localparam logic [ADDR_W-1:0] CMD_A = ADDR_W'(CMD_ADDR);

  logic wr_n_q;
  logic hit_q;
  logic bit_q;
  logic strobe_end;
  logic unused_wdata;

  // Bus view from the previous cycle: the values present while the strobe was low
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_n_q <= 1'b1;
      hit_q  <= 1'b0;
      bit_q  <= 1'b1;
    end else begin
      wr_n_q <= wr_n;
      hit_q  <= !sel_n && (addr == CMD_A);
      bit_q  <= wdata[CMD_BIT];
    end
  end

  assign strobe_end = !wr_n_q && wr_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      route <= ROUTE_DISK;
    end else if (strobe_end && hit_q) begin
      route <= route_e'(bit_q);
    end
  end

  assign unused_wdata = ^wdata;
endmodule

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int unsigned WIDTH  = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);
  for (genvar s = 0; s < WIDTH; s++) begin : g_src
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        chain <= '0;
      end else if (STAGES == 1) begin
        chain <= async_in[s];
      end else begin
        chain <= {chain[STAGES-2:0], async_in[s]};
      end
    end

    assign sync_out[s] = chain[STAGES-1];
  end
endmodule

// File: rtl/irq_route_mux.sv
module irq_route_mux (
  input  irq_src_pkg::route_e                        route,
  input  logic [irq_src_pkg::SRC_COUNT-1:0]          src_irq,
  output logic                                       irq_out
);
  import irq_src_pkg::*;

  always_comb begin
    unique case (route)
      ROUTE_DMA:  irq_out = src_irq[SRC_DMA];
      ROUTE_DISK: irq_out = src_irq[SRC_DISK];
      default:    irq_out = 1'b0;
    endcase
  end
endmodule

// File: rtl/irq_src_sel.sv
module irq_src_sel #(
  parameter int unsigned ADDR_W      = 3,
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned CMD_ADDR    = 7,
  parameter int unsigned CMD_BIT     = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel_n,
  input  logic              bus_wr_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              dma_irq,
  input  logic              disk_irq,
  output logic              sys_irq
);
  import irq_src_pkg::*;

  route_e               route;
  logic [SRC_COUNT-1:0] raw_irq;
  logic [SRC_COUNT-1:0] synced_irq;

  assign raw_irq[SRC_DMA]  = dma_irq;
  assign raw_irq[SRC_DISK] = disk_irq;

  cmd_snoop #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .CMD_ADDR(CMD_ADDR),
    .CMD_BIT (CMD_BIT)
  ) u_snoop (
    .clk  (clk),
    .rst_n(rst_n),
    .sel_n(bus_sel_n),
    .wr_n (bus_wr_n),
    .addr (bus_addr),
    .wdata(bus_wdata),
    .route(route)
  );

  irq_sync #(
    .WIDTH (SRC_COUNT),
    .STAGES(SYNC_STAGES)
  ) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_in(raw_irq),
    .sync_out(synced_irq)
  );

  irq_route_mux u_mux (
    .route  (route),
    .src_irq(synced_irq),
    .irq_out(sys_irq)
  );
endmodule

// File: rtl/irq_src_sel_chk.sv
module irq_src_sel_chk #(
  parameter int unsigned ADDR_W   = 3,
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned CMD_ADDR = 7,
  parameter int unsigned CMD_BIT  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel_n,
  input logic              bus_wr_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              dma_irq,
  input logic              disk_irq,
  input logic              sys_irq,
  input logic              route_bit
);
  logic [1:0] cyc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cyc <= '0;
    else if (cyc != 2'd3) cyc <= cyc + 2'd1;
  end

  // R1
  reset_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!sys_irq && route_bit));

  // R2
  dma_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc == 2'd3 && !route_bit) |-> (sys_irq == $past(dma_irq, 2)));

  // R3
  disk_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc == 2'd3 && route_bit) |-> (sys_irq == $past(disk_irq, 2)));

  // R4
  capture_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc == 2'd3 && !$stable(route_bit)) |->
      ($past(bus_wr_n) && !$past(bus_wr_n, 2) && !$past(bus_sel_n, 2) &&
       ($past(bus_addr, 2) == ADDR_W'(CMD_ADDR))));

  // R6
  capture_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc == 2'd3 && !$stable(route_bit)) |-> (route_bit == $past(bus_wdata[CMD_BIT], 2)));
endmodule

bind irq_src_sel irq_src_sel_chk #(
  .ADDR_W  (ADDR_W),
  .DATA_W  (DATA_W),
  .CMD_ADDR(CMD_ADDR),
  .CMD_BIT (CMD_BIT)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .bus_sel_n(bus_sel_n),
  .bus_wr_n (bus_wr_n),
  .bus_addr (bus_addr),
  .bus_wdata(bus_wdata),
  .dma_irq  (dma_irq),
  .disk_irq (disk_irq),
  .sys_irq  (sys_irq),
  .route_bit(route)
);

// File: tb/test_irq_src_sel.sv
`timescale 1ns/100ps
module test_irq_src_sel;
  localparam int unsigned MAX_CYCLES = 200000;

  typedef struct {
    logic  exp;
    string tag;
  } item_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_sel_n = 1'b1;
  logic       bus_wr_n = 1'b1;
  logic [2:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic       dma_irq = 1'b0;
  logic       disk_irq = 1'b0;
  logic       sys_irq;

  int    checks = 0;
  int    errors = 0;
  item_t sb_q[$];
  bit    done = 1'b0;

  always #2 clk = ~clk;

  irq_src_sel i_irq_src_sel (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_sel_n(bus_sel_n),
    .bus_wr_n (bus_wr_n),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .dma_irq  (dma_irq),
    .disk_irq (disk_irq),
    .sys_irq  (sys_irq)
  );

  // Monitor: compares queued expectations 1 ns after each falling edge
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (sb_q.size() > 0) begin
        item_t it;
        it = sb_q.pop_front();
        checks++;
        if (sys_irq !== it.exp) begin
          errors++;
          $display("FAIL %s: sys_irq=%b expected=%b", it.tag, sys_irq, it.exp);
        end
      end
    end
  end

  task automatic expect_irq(input logic e, input string tag);
    sb_q.push_back('{exp: e, tag: tag});
  endtask

  task automatic ticks(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Host write: strobe low for one cycle; data may change as the strobe rises
  task automatic host_write(input logic [2:0] a, input logic [7:0] d,
                            input logic sel, input logic [7:0] d_late);
    @(negedge clk);
    bus_sel_n = !sel;
    bus_addr  = a;
    bus_wdata = d;
    bus_wr_n  = 1'b0;
    @(negedge clk);
    bus_wr_n  = 1'b1;
    bus_wdata = d_late;
    @(negedge clk);
    bus_sel_n = 1'b1;
    bus_wdata = 8'h00;
  endtask

  initial begin
    ticks(1);
    expect_irq(1'b0, "R1 in reset");
    ticks(2);
    rst_n = 1'b1;
    dma_irq = 1'b1;
    ticks(1);
    expect_irq(1'b0, "R1 first clock after reset");
    ticks(3);
    expect_irq(1'b0, "R1 default route ignores dma_irq");

    // disk path latency with default route
    disk_irq = 1'b1;
    ticks(1);
    expect_irq(1'b0, "R7 not after one edge");
    ticks(1);
    expect_irq(1'b1, "R7 disk after two edges");
    disk_irq = 1'b0;
    ticks(2);
    expect_irq(1'b0, "R3 disk deassert followed");

    // sector read command -> DMA source
    host_write(3'd7, 8'h20, 1'b1, 8'h20);
    expect_irq(1'b1, "R2 read selects dma");
    dma_irq = 1'b0;
    ticks(1);
    expect_irq(1'b1, "R7 dma drop not after one edge");
    ticks(1);
    expect_irq(1'b0, "R2 dma drop after two edges");
    disk_irq = 1'b1;
    ticks(3);
    expect_irq(1'b0, "R8 disk ignored on dma route");
    disk_irq = 1'b0;
    dma_irq = 1'b1;
    ticks(3);
    expect_irq(1'b1, "R2 dma raise followed");

    // wrong address and inactive select leave route on DMA
    host_write(3'd6, 8'h10, 1'b1, 8'h10);
    ticks(1);
    expect_irq(1'b1, "R4 other address ignored");
    host_write(3'd7, 8'h10, 1'b0, 8'h10);
    ticks(1);
    expect_irq(1'b1, "R5 inactive select ignored");

    // only bit 4 matters
    host_write(3'd7, 8'hEF, 1'b1, 8'hEF);
    ticks(1);
    expect_irq(1'b1, "R9 bit4 clear with others set keeps dma");
    host_write(3'd7, 8'h10, 1'b1, 8'h10);
    expect_irq(1'b0, "R3 non-read selects disk");
    disk_irq = 1'b1;
    ticks(2);
    expect_irq(1'b1, "R3 disk raise followed");
    dma_irq = 1'b0;
    ticks(3);
    expect_irq(1'b1, "R8 dma ignored on disk route");

    // capture uses data from strobe-low cycle
    host_write(3'd7, 8'h00, 1'b1, 8'h10);
    expect_irq(1'b0, "R6 late data ignored, dma route");
    host_write(3'd7, 8'h10, 1'b1, 8'h00);
    expect_irq(1'b1, "R6 late data ignored, disk route");

    ticks(3);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (MAX_CYCLES) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run hung, actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule